// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. Its instruction and data ports are separate, so a fetch and a data access can both happen in the same cycle. The core drives the fetch address and takes the instruction word back in the same cycle. It drives the data address, the store data and a write strobe, and takes load data back combinationally. Both memories sit outside the core, as combinational-read, clocked-write arrays.

The core decodes nine instructions: load word, store word, add, subtract, AND, OR, signed set-less-than, branch-if-equal and jump. Inside it are a program-counter register, a register file with two read ports and one write port, a sign extender, a branch-target adder, an instruction decoder and an ALU. Multiplexers choose the ALU operand, the write-back source and the next PC. Any encoding outside the supported set retires as a no-op.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 on that edge, and no data-memory write is issued.
- R2: After load word, store word and every R-type or no-op instruction, the next PC is the current PC plus 4.
- R3: Load word (opcode 35) and store word (opcode 43) use the byte address rs + sign-extended bits 15:0. A load writes the loaded word into register rt.
- R4: R-type instructions (opcode 0) write register rd with rs op rt. The funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than, which gives 1 or 0.
- R5: Branch-if-equal (opcode 4) compares rs and rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2; otherwise it is PC+4. Negative displacements branch backwards.
- R6: Jump (opcode 2) loads the PC with PC bits 31:28, followed by instruction bits 25:0, followed by two zero bits.
- R7: Register 0 always reads as zero, and a write aimed at it has no effect.
- R8: An unsupported opcode, or an R-type word with an unlisted funct, changes no register and no memory, and advances the PC by 4.
- R9: The data write strobe is raised only for store word, and the data written is the value of register rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench builds the core with its default 32-bit width and 32 registers. It attaches 64-word instruction and data memories, which leaves enough room for a 26-instruction program. That program touches every instruction class, both branch directions, a backward branch, a jump, a write to register 0 and both kinds of illegal encoding. The program is run for every ordered pair drawn from eight operand values: zero, ±1, ±5, the most positive and most negative words, and an alternating pattern. This brings every ALU function, signed-compare overflow cases and both branch outcomes within reach, and each pair is checked against arithmetic done in the bench.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    mem_we;
        logic    is_branch;
        logic    is_jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
                 mem_we: 1'b0, is_branch: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OPC_JUMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic [RIDX-1:0] ra,
    input  logic [RIDX-1:0] rb,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    input  logic            we,
    input  logic [RIDX-1:0] wa,
    input  logic [XLEN-1:0] wdata
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs_q[wa] <= wdata;
        end
    end

    assign ra_data = (ra == '0) ? '0 : regs_q[ra];
    assign rb_data = (rb == '0) ? '0 : regs_q[rb];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int RIDX   = $clog2(NREGS);
    localparam int IMM_W  = 16;
    localparam int JFLD_W = 26;
    localparam int PC_HI  = XLEN - JFLD_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [5:0]      opcode, funct;
    logic [RIDX-1:0] rs, rt, rd, wa;
    logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, wb_val;
    logic [XLEN-1:0] pc_inc, pc_branch, pc_jump;
    logic            alu_zero;
    ctrl_t           ctrl;

    assign opcode = imem_rdata[31:26];
    assign funct  = imem_rdata[5:0];
    assign rs     = imem_rdata[21 +: RIDX];
    assign rt     = imem_rdata[16 +: RIDX];
    assign rd     = imem_rdata[11 +: RIDX];
    assign imm_sx = {{(XLEN-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};

    sc_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .ra      (rs),
        .rb      (rt),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .we      (ctrl.reg_we & ~rst),
        .wa      (wa),
        .wdata   (wb_val)
    );

    assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wa     = ctrl.dst_is_rd ? rd : rt;
    assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    assign pc_inc    = st_q.pc + XLEN'(4);
    assign pc_branch = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
    assign pc_jump   = {st_q.pc[XLEN-1 -: PC_HI], imem_rdata[JFLD_W-1:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.is_jump) begin
            st_d.pc = pc_jump;
        end else if (ctrl.is_branch && alu_zero) begin
            st_d.pc = pc_branch;
        end else begin
            st_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & ~rst;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic            dmem_we
);

    logic [5:0]      op;
    logic [XLEN-1:0] disp;

    assign op   = imem_rdata[31:26];
    assign disp = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (imem_addr == '0)); // R1

    AST_NO_STORE_IN_RESET: assert property (@(posedge clk)
        rst |-> !dmem_we); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (op != 6'd2 && op != 6'd4) |=> (imem_addr == $past(imem_addr) + XLEN'(4))); // R2

    AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd4) |=> ((imem_addr == $past(imem_addr) + XLEN'(4)) ||
                          (imem_addr == $past(imem_addr) + XLEN'(4) + $past(disp)))); // R5

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd2) |=> (imem_addr == {$past(imem_addr[XLEN-1 -: XLEN-28]),
                                        $past(imem_rdata[25:0]), 2'b00})); // R6

    AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == 6'd43)); // R9

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

    localparam int XLEN  = 32;
    localparam int MWORDS = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [XLEN-1:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic            dmem_we;

    logic [XLEN-1:0] imem [MWORDS];
    logic [XLEN-1:0] dmem [MWORDS];

    int n_checks = 0;
    int n_fail   = 0;
    int n_stores = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sc_core #(.XLEN(XLEN), .NREGS(32)) u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_addr[7:2]] <= dmem_wdata;
            n_stores <= n_stores + 1;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_pair(logic [31:0] a, logic [31:0] b, bit first);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < MWORDS; i++) dmem[i] = '0;
        dmem[0] = a;
        dmem[1] = b;
        dmem[2] = 32'h1111_1111;
        dmem[3] = 32'h2222_2222;
        n_stores = 0;
        @(posedge clk);
        @(negedge clk);
        if (first) check("R1 reset pc", imem_addr, 32'h0);
        if (first) check("R1 no store in reset", {31'd0, dmem_we}, 32'h0);
        rst = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        check("R4 add",  dmem[4], a + b);
        check("R4 sub",  dmem[5], a - b);
        check("R4 and",  dmem[6], a & b);
        check("R4 or",   dmem[7], a | b);
        check("R4 slt",  dmem[8], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R5 beq skip", dmem[10], (a == b) ? 32'h0 : 32'h1111_1111);
        check("R3 lw/sw path", dmem[11], 32'h2222_2222);
        check("R7 r0 stays zero", dmem[12], 32'h0);
        check("R8 illegal opcode no store", dmem[13], 32'h0);
        check("R6 jump skips", dmem[15], 32'h0);
        check("R8 illegal funct keeps r9", dmem[14], 32'h2222_2222);
        check("R9 store count", 32'(n_stores), (a == b) ? 32'd8 : 32'd9);
        check("R5 backward branch spin pc", imem_addr, 32'd100);
    endtask

    initial begin
        logic [31:0] vals [8];
        vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h0F0F_0F0F};
        for (int i = 0; i < MWORDS; i++) imem[i] = 32'hFC00_0000;
        imem[0]  = enc_i(6'd35, 0, 1, 16'd0);        // R3 load a
        imem[1]  = enc_i(6'd35, 0, 2, 16'd4);        // load b
        imem[2]  = enc_r(1, 2, 3, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 6'h22);
        imem[4]  = enc_r(1, 2, 5, 6'h24);
        imem[5]  = enc_r(1, 2, 6, 6'h25);
        imem[6]  = enc_r(1, 2, 7, 6'h2A);
        imem[7]  = enc_i(6'd43, 0, 3, 16'd16);
        imem[8]  = enc_i(6'd43, 0, 4, 16'd20);
        imem[9]  = enc_i(6'd43, 0, 5, 16'd24);
        imem[10] = enc_i(6'd43, 0, 6, 16'd28);
        imem[11] = enc_i(6'd43, 0, 7, 16'd32);
        imem[12] = enc_i(6'd35, 0, 8, 16'd8);
        imem[13] = enc_i(6'd35, 0, 9, 16'd12);
        imem[14] = enc_i(6'd4, 1, 2, 16'd1);         // R5 forward branch
        imem[15] = enc_i(6'd43, 0, 8, 16'd40);
        imem[16] = enc_i(6'd43, 0, 9, 16'd44);
        imem[17] = enc_r(1, 2, 0, 6'h20);            // R7 write to r0
        imem[18] = enc_i(6'd43, 0, 0, 16'd48);
        imem[19] = enc_r(1, 2, 9, 6'h3F);            // R8 unlisted funct
        imem[20] = enc_i(6'h3F, 0, 8, 16'd52);       // R8 unsupported opcode
        imem[21] = {6'd2, 26'd24};                   // R6 jump
        imem[22] = enc_i(6'd43, 0, 8, 16'd60);
        imem[23] = enc_i(6'd43, 0, 8, 16'd60);
        imem[24] = enc_i(6'd43, 0, 9, 16'd56);
        imem[25] = enc_i(6'd4, 0, 0, 16'hFFFF);      // R5 backward spin
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_pair(vals[i], vals[j], (i == 0 && j == 0));
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule